// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple 32-bit in-order processor and picks the address of the next instruction on every enabled clock edge. It looks at the instruction being executed now, together with two register operands and one register target value, and chooses one of four sources for the next address. The sources are the sequential step, a conditional PC-relative branch, an absolute jump that keeps the current PC's top nibble, and a jump through a register.

A jump-and-link instruction also presents its return address on a separate output in the same cycle, so that the register file can capture it. An advance enable freezes the counter while the rest of the pipeline is stalled. A synchronous reset places the counter at the program entry point. Instruction fetch, the register file and the ALU sit outside this block. All ports are plain control and data pins with no handshake, because the PC moves in lock-step with execution.

Top module: `next_pc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_q` becomes 0x00400000 on that edge, whatever `adv_en` and the instruction are.
- R2: When `rst` is low and `adv_en` is low at an edge, `pc_q` keeps its value for any instruction or operand values.
- R3: The opcode is `instr[31:26]` and the function code is `instr[5:0]`. An instruction that is not a branch or jump takes `pc_q` to `pc_q + 4`. This covers any opcode other than 0, 2, 3, 4 and 5, and opcode 0 with any function code other than 8.
- R4: Opcode 4 (branch-if-equal) with `opnd_a == opnd_b` takes `pc_q` to `pc_q + 4 + (sext(instr[15:0]) << 2)`. When the operands differ, it takes `pc_q` to `pc_q + 4`.
- R5: Opcode 5 (branch-if-different) is taken when `opnd_a != opnd_b`, using the same target rule as R4. Otherwise it advances to `pc_q + 4`.
- R6: Opcode 2 (jump) loads `{pc_q[31:28], instr[25:0], 2'b00}`.
- R7: Opcode 3 (jump-and-link) loads the same target as R6. While it is presented, `link_addr` equals `pc_q + 4`. For every other instruction, `link_addr` is zero.
- R8: Opcode 0 with function code 8 (register jump) loads `reg_tgt` unchanged into `pc_q`.
- R9: All address sums wrap modulo 2^32.
- R10: The branch offset in `instr[15:0]` is two's complement. 0xFFFF steps back one word from PC+4, 0x8000 reaches -32768 words and 0x7FFF reaches +32767 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; low holds the PC |
| instr | input | 32 | Instruction currently executing |
| opnd_a | input | 32 | First compared register operand |
| opnd_b | input | 32 | Second compared register operand |
| reg_tgt | input | 32 | Register value used by the register jump |
| pc_q | output | 32 | Current program counter |
| link_addr | output | 32 | Return address for jump-and-link, else zero |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 16-bit branch offset, a 26-bit jump field and the 0x00400000 entry point. With a 32-bit counter, the register jump can place the PC just below 2^32. This lets the sequential step and a forward branch wrap through zero, and lets an absolute jump run from the top nibble 0xF. The 16-bit offset makes both signed extremes, 0x8000 and 0x7FFF, reachable in a single vector.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int ILEN  = 32;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JMP     = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQ     = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE     = 6'd5;
  localparam logic [FN_W-1:0]  FN_JREG     = 6'd8;

  typedef enum logic [1:0] {
    NXT_SEQ = 2'd0,
    NXT_REL = 2'd1,
    NXT_ABS = 2'd2,
    NXT_REG = 2'd3
  } nxt_src_e;

endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic            same
);
  logic [XLEN-1:0] bit_diff;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign bit_diff[i] = lhs[i] ^ rhs[i];
  end

  assign same = ~|bit_diff;
endmodule

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             ops_same,
  output nxt_src_e         src,
  output logic             is_link
);
  always_comb begin
    src     = NXT_SEQ;
    is_link = 1'b0;
    unique case (opcode)
      OPC_SPECIAL: if (funct == FN_JREG) src = NXT_REG;
      OPC_JMP:     src = NXT_ABS;
      OPC_JAL: begin
        src     = NXT_ABS;
        is_link = 1'b1;
      end
      OPC_BEQ:     if (ops_same)  src = NXT_REL;
      OPC_BNE:     if (!ops_same) src = NXT_REL;
      default:     src = NXT_SEQ;
    endcase
  end

  always_comb begin
    if (is_link) AST_LINK_IS_ABS: assert (src == NXT_ABS); // R7
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  logic [TGT_W-1:0] jfield,
  input  logic [XLEN-1:0]  reg_tgt,
  input  nxt_src_e         src,
  output logic [XLEN-1:0]  seq_addr,
  output logic [XLEN-1:0]  nxt_addr
);
  localparam int          EXT_W = XLEN - OFF_W - 2;
  localparam int          KEEP_W = XLEN - TGT_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] byte_off;
  logic [XLEN-1:0] rel_addr;
  logic [XLEN-1:0] abs_addr;

  assign seq_addr = pc + STEP;
  assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign rel_addr = seq_addr + byte_off;

  if (KEEP_W > 0) begin : g_keep_upper
    assign abs_addr = {pc[XLEN-1 -: KEEP_W], jfield, 2'b00};
  end else begin : g_full_field
    assign abs_addr = {jfield[XLEN-3:0], 2'b00};
  end

  always_comb begin
    unique case (src)
      NXT_SEQ: nxt_addr = seq_addr;
      NXT_REL: nxt_addr = rel_addr;
      NXT_ABS: nxt_addr = abs_addr;
      NXT_REG: nxt_addr = reg_tgt;
      default: nxt_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              OFF_W      = 16,
  parameter int              TGT_W      = 26,
  parameter logic [XLEN-1:0] RESET_ADDR = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_en,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] link_addr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [OPC_W-1:0] opcode;
  logic [FN_W-1:0]  funct;
  logic             ops_same;
  logic             is_link;
  nxt_src_e         src;
  logic [XLEN-1:0]  seq_addr;
  logic [XLEN-1:0]  nxt_addr;

  assign opcode = instr[ILEN-1 -: OPC_W];
  assign funct  = instr[FN_W-1:0];

  npc_cmp #(.XLEN(XLEN)) u_cmp (
    .lhs  (opnd_a),
    .rhs  (opnd_b),
    .same (ops_same)
  );

  npc_decode u_dec (
    .opcode   (opcode),
    .funct    (funct),
    .ops_same (ops_same),
    .src      (src),
    .is_link  (is_link)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
    .pc       (pc_q),
    .offset   (instr[OFF_W-1:0]),
    .jfield   (instr[TGT_W-1:0]),
    .reg_tgt  (reg_tgt),
    .src      (src),
    .seq_addr (seq_addr),
    .nxt_addr (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= RESET_ADDR;
    else if (adv_en) pc_q <= nxt_addr;
  end

  assign link_addr = is_link ? seq_addr : '0;

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> pc_q == RESET_ADDR); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_q)); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    adv_en && src == NXT_SEQ |=> pc_q == $past(pc_q) + STEP); // R3
  AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    adv_en && opcode == OPC_BEQ && opnd_a != opnd_b |=> pc_q == $past(pc_q) + STEP); // R4
  AST_BNE_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    adv_en && opcode == OPC_BNE && opnd_a == opnd_b |=> pc_q == $past(pc_q) + STEP); // R5
  AST_ABS_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
    adv_en && (opcode == OPC_JMP || opcode == OPC_JAL) |=>
      pc_q[XLEN-1 -: 4] == $past(pc_q[XLEN-1 -: 4]) && pc_q[1:0] == 2'b00); // R6
  AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
    opcode != OPC_JAL |-> link_addr == '0); // R7
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
    adv_en && opcode == OPC_SPECIAL && funct == FN_JREG |=> pc_q == $past(reg_tgt)); // R8
endmodule

// File: tb/next_pc_unit_bench.sv
module next_pc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] reg_tgt = '0;
  logic [31:0] pc_q;
  logic [31:0] link_addr;
  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [31:0] JREG_I = 32'h0000_0008;

  next_pc_unit u_next_pc_unit (
    .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .reg_tgt(reg_tgt),
    .pc_q(pc_q), .link_addr(link_addr)
  );

  always #5 clk = ~clk;

  // fields: requirement, start pc, instruction, operand a, operand b, expected next pc
  localparam int NV = 16;
  localparam logic [167:0] VEC [NV] = '{
    {8'd3,  32'h0040_0000, 32'h0000_1025, 32'd0, 32'd0, 32'h0040_0004}, // R3 opcode 0 non-jump
    {8'd4,  32'h0040_0008, 32'h1100_0003, 32'd0, 32'd0, 32'h0040_0018}, // R4 equal, taken
    {8'd4,  32'h0040_0008, 32'h1100_0003, 32'd1, 32'd0, 32'h0040_000C}, // R4 differ, fall through
    {8'd5,  32'h0040_0008, 32'h1500_0003, 32'd1, 32'd0, 32'h0040_0018}, // R5 differ, taken
    {8'd5,  32'h0040_0008, 32'h1500_0003, 32'd5, 32'd5, 32'h0040_000C}, // R5 equal, fall through
    {8'd6,  32'h0040_0014, 32'h0810_0001, 32'd0, 32'd0, 32'h0040_0004}, // R6 jump
    {8'd6,  32'hA000_0000, 32'h0BFF_FFFF, 32'd0, 32'd0, 32'hAFFF_FFFC}, // R6 all-ones field
    {8'd7,  32'h3000_0100, 32'h0C00_0010, 32'd0, 32'd0, 32'h3000_0040}, // R7 jump-and-link
    {8'd10, 32'h0040_0010, 32'h1000_FFFF, 32'd7, 32'd7, 32'h0040_0010}, // R10 offset -1
    {8'd10, 32'h0040_0000, 32'h1000_8000, 32'd0, 32'd0, 32'h003E_0004}, // R10 most negative
    {8'd10, 32'h0040_0000, 32'h1000_7FFF, 32'd0, 32'd0, 32'h0042_0000}, // R10 most positive
    {8'd3,  32'h0040_0010, 32'h20A5_FFFF, 32'd0, 32'd0, 32'h0040_0014}, // R3 other opcode
    {8'd3,  32'h0000_1000, 32'h0044_1020, 32'd3, 32'd3, 32'h0000_1004}, // R3 opcode 0 funct 0x20
    {8'd9,  32'hFFFF_FFFC, 32'h0000_0000, 32'd0, 32'd0, 32'h0000_0000}, // R9 sequential wrap
    {8'd9,  32'hFFFF_FFF0, 32'h1000_0004, 32'd9, 32'd9, 32'h0000_0004}, // R9 branch wrap
    {8'd6,  32'hFFFF_FFFC, 32'h0800_0000, 32'd0, 32'd0, 32'hF000_0000}  // R6 top nibble F
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] t);
    instr = ins; opnd_a = a; opnd_b = b; reg_tgt = t;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_pc(input logic [31:0] v);
    adv_en = 1'b1;
    drive(JREG_I, 32'd0, 32'd0, v);
    tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(); tick();
    check("R1 reset value", pc_q, 32'h0040_0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      set_pc(VEC[i][159:128]);
      drive(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], 32'h5555_0000);
      tick();
      check($sformatf("R%0d vector %0d", VEC[i][167:160], i), pc_q, VEC[i][31:0]);
    end

    // R8 register jump loads raw value, including unaligned bits
    set_pc(32'h1234_5679);
    check("R8 register jump", pc_q, 32'h1234_5679);

    // R7 link output during jump-and-link, zero otherwise
    set_pc(32'h3000_0100);
    drive(32'h0C00_0010, 32'd0, 32'd0, 32'd0);
    #1 check("R7 link during jal", link_addr, 32'h3000_0104);
    drive(32'h0800_0010, 32'd0, 32'd0, 32'd0);
    #1 check("R7 link zero for jump", link_addr, 32'h0000_0000);

    // R2 hold when advance enable low
    set_pc(32'h0000_8000);
    adv_en = 1'b0;
    drive(32'h0800_0040, 32'd0, 32'd0, 32'd0);
    tick();
    check("R2 hold under jump", pc_q, 32'h0000_8000);
    drive(JREG_I, 32'd0, 32'd0, 32'hDEAD_BEEC);
    tick();
    check("R2 hold under register jump", pc_q, 32'h0000_8000);

    // R1 reset wins over hold and over a jump
    rst = 1'b1;
    tick();
    check("R1 reset while held", pc_q, 32'h0040_0000);
    rst = 1'b0;
    set_pc(32'h7000_0000);
    rst = 1'b1;
    adv_en = 1'b1;
    drive(32'h0800_0040, 32'd0, 32'd0, 32'd0);
    tick();
    check("R1 reset over jump", pc_q, 32'h0040_0000);
    rst = 1'b0;
    drive(32'h0000_1025, 32'd0, 32'd0, 32'd0);
    tick();
    check("R3 step after reset", pc_q, 32'h0040_0004);

    finish_run();
  end
endmodule